// File: doc/BRIEF.md
# Stack Pointer Bounds Monitor

This block sits beside a processor core and compares the core's live stack pointer against a programmable floor and ceiling every cycle in which the core marks its outputs valid. A pointer below the floor or above the ceiling is a violation. Each violation kind has its own bit in a watch mask. Software can read the resulting flags directly, so it can poll for a stack overrun without taking an interrupt.

A second mask, the arm mask, decides which watched violations are copied into internal state flops. These flops drive one combined interrupt line. Writing ones to the acknowledge register clears the chosen state flops and leaves the readable flags alone. On the first cycle in which any flag goes high, the block also records the core's program counter. A bus clock enable stops all register updates. A software reset input returns every register to zero.

Top module: `sp_bounds_mon`

## Requirements
- R1: Flag bit 1 (word 5) is high in the same cycle when core_valid is high, the stack pointer is strictly greater than the ceiling register (word 1) and watch bit 1 is set; equality does not raise it.
- R2: Flag bit 0 (word 5) is high in the same cycle when core_valid is high, the stack pointer is strictly less than the floor register (word 0) and watch bit 0 is set; equality does not raise it.
- R3: A condition whose watch bit (word 2) is zero reads as zero in the flag word and never reaches the interrupt.
- R4: On each clock edge with clk_en high, each state flop loads its flag bit ANDed with its arm bit (word 3). irq is the OR of the state flops, so it follows one cycle after the flag.
- R5: Writing word 4 with bit i set clears state flop i on that edge, ahead of the normal load. Other state bits and the flag word are unaffected.
- R6: rst or soft_rst zeroes every register, state flop and the captured program counter, with priority over acknowledge and load.
- R7: Floor and ceiling are 32-bit read/write. Watch and arm read back their last written 2-bit values. Word 4 and word 7 read as zero.
- R8: Word 6 loads core_pc on the first enabled edge at which any flag bit is high. It then holds until a write to word 4 with a nonzero low two bits, which zeroes it and re-arms the capture.
- R9: While clk_en is low, register writes are ignored, and the state flops, irq and word 6 hold.
- R10: With core_valid low, no flag bit is raised whatever the stack pointer is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Bus clock enable for all register updates |
| soft_rst | input | 1 | Software-driven synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| core_sp | input | 32 | Live stack pointer |
| core_pc | input | 32 | Live program counter |
| core_valid | input | 1 | Core sample valid strobe |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is an acknowledge that lands while the violation is still present. The state flop must drop for exactly one edge, the flag word must stay high throughout, and the program counter capture must re-arm and take the new core_pc on the next edge. Directed steps build this case for one bit and for both bits. They also cover clk_en being low during a violation. A seeded random phase then keeps the stack pointer within a few counts of each bound while it toggles masks, acknowledges, clock enable and soft reset. This exercises the boundary equalities and the priority overlaps many times.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int NCOND   = 2;
    localparam int COND_LO = 0;
    localparam int COND_HI = 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_FLOOR  = 3'd0,
        REG_CEIL   = 3'd1,
        REG_WATCH  = 3'd2,
        REG_ARM    = 3'd3,
        REG_ACK    = 3'd4,
        REG_FLAG   = 3'd5,
        REG_TRAPPC = 3'd6
    } reg_idx_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] sp;
        logic [DATA_W-1:0] pc;
    } core_sample_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    function automatic logic [DATA_W-1:0] widen(input logic [NCOND-1:0] v);
        return {{(DATA_W-NCOND){1'b0}}, v};
    endfunction
endpackage

// File: rtl/sbm_cmp.sv
module sbm_cmp
    import sbm_pkg::*;
(
    input  core_sample_t             core,
    input  logic [DATA_W-1:0]        floor_q,
    input  logic [DATA_W-1:0]        ceil_q,
    input  logic [NCOND-1:0]         watch_q,
    output logic [NCOND-1:0]         raw
);
    logic [NCOND-1:0] cond;

    for (genvar gi = 0; gi < NCOND; gi++) begin : g_cond
        if (gi == COND_LO) begin : g_lo
            assign cond[gi] = core.valid && (core.sp < floor_q);
        end else if (gi == COND_HI) begin : g_hi
            assign cond[gi] = core.valid && (core.sp > ceil_q);
        end else begin : g_none
            assign cond[gi] = 1'b0;
        end
    end

    assign raw = cond & watch_q;
endmodule

// File: rtl/sbm_regs.sv
module sbm_regs
    import sbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_all,
    input  logic              clk_en,
    input  reg_req_t          req,
    input  logic [NCOND-1:0]  raw,
    input  logic [DATA_W-1:0] trap_pc,
    output logic [DATA_W-1:0] floor_q,
    output logic [DATA_W-1:0] ceil_q,
    output logic [NCOND-1:0]  watch_q,
    output logic [NCOND-1:0]  arm_q,
    output logic [NCOND-1:0]  clr,
    output logic [DATA_W-1:0] rdata
);
    logic wr;
    assign wr = req.we & clk_en;

    always_ff @(posedge clk) begin
        if (rst_all) begin
            floor_q <= '0;
            ceil_q  <= '0;
            watch_q <= '0;
            arm_q   <= '0;
        end else if (wr) begin
            case (req.addr)
                REG_FLOOR: floor_q <= req.wdata;
                REG_CEIL:  ceil_q  <= req.wdata;
                REG_WATCH: watch_q <= req.wdata[NCOND-1:0];
                REG_ARM:   arm_q   <= req.wdata[NCOND-1:0];
                default: ;
            endcase
        end
    end

    assign clr = (wr && (req.addr == REG_ACK)) ? req.wdata[NCOND-1:0] : '0;

    always_comb begin
        case (req.addr)
            REG_FLOOR:  rdata = floor_q;
            REG_CEIL:   rdata = ceil_q;
            REG_WATCH:  rdata = widen(watch_q);
            REG_ARM:    rdata = widen(arm_q);
            REG_FLAG:   rdata = widen(raw);
            REG_TRAPPC: rdata = trap_pc;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/sbm_latch.sv
module sbm_latch
    import sbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_all,
    input  logic              clk_en,
    input  logic [NCOND-1:0]  raw,
    input  logic [NCOND-1:0]  arm_q,
    input  logic [NCOND-1:0]  clr,
    input  logic [DATA_W-1:0] core_pc,
    output logic [NCOND-1:0]  state_q,
    output logic [DATA_W-1:0] trap_pc_q,
    output logic              cap_q,
    output logic              irq
);
    for (genvar gi = 0; gi < NCOND; gi++) begin : g_state
        always_ff @(posedge clk) begin
            if (rst_all) begin
                state_q[gi] <= 1'b0;
            end else if (clk_en) begin
                if (clr[gi]) state_q[gi] <= 1'b0;
                else         state_q[gi] <= raw[gi] & arm_q[gi];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst_all) begin
            trap_pc_q <= '0;
            cap_q     <= 1'b0;
        end else if (clk_en) begin
            if (|clr) begin
                trap_pc_q <= '0;
                cap_q     <= 1'b0;
            end else if ((|raw) && !cap_q) begin
                trap_pc_q <= core_pc;
                cap_q     <= 1'b1;
            end
        end
    end

    assign irq = |state_q;
endmodule

// File: rtl/sp_bounds_mon.sv
module sp_bounds_mon
    import sbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              soft_rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] core_sp,
    input  logic [DATA_W-1:0] core_pc,
    input  logic              core_valid,
    output logic              irq
);
    logic              rst_all;
    core_sample_t      core;
    reg_req_t          req;
    logic [DATA_W-1:0] floor_q, ceil_q, trap_pc_q;
    logic [NCOND-1:0]  watch_q, arm_q, clr_w, raw_w, state_q;
    logic              cap_q;

    assign rst_all = rst | soft_rst;
    assign core    = '{valid: core_valid, sp: core_sp, pc: core_pc};
    assign req     = '{we: reg_we, addr: reg_addr, wdata: reg_wdata};

    sbm_cmp cmp_i (
        .core    (core),
        .floor_q (floor_q),
        .ceil_q  (ceil_q),
        .watch_q (watch_q),
        .raw     (raw_w)
    );

    sbm_regs regs_i (
        .clk     (clk),
        .rst_all (rst_all),
        .clk_en  (clk_en),
        .req     (req),
        .raw     (raw_w),
        .trap_pc (trap_pc_q),
        .floor_q (floor_q),
        .ceil_q  (ceil_q),
        .watch_q (watch_q),
        .arm_q   (arm_q),
        .clr     (clr_w),
        .rdata   (reg_rdata)
    );

    sbm_latch latch_i (
        .clk       (clk),
        .rst_all   (rst_all),
        .clk_en    (clk_en),
        .raw       (raw_w),
        .arm_q     (arm_q),
        .clr       (clr_w),
        .core_pc   (core.pc),
        .state_q   (state_q),
        .trap_pc_q (trap_pc_q),
        .cap_q     (cap_q),
        .irq       (irq)
    );
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker
    import sbm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              soft_rst,
    input logic              clk_en,
    input logic              core_valid,
    input logic              irq,
    input logic [DATA_W-1:0] trap_pc,
    input logic              captured,
    input logic [NCOND-1:0]  raw,
    input logic [NCOND-1:0]  arm,
    input logic [NCOND-1:0]  clr
);
    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !soft_rst && clr == '0 && (raw & arm) != '0) |=> irq);

    p_noarm_r4: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !soft_rst && (raw & arm) == '0) |=> !irq);

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !soft_rst && (&clr)) |=> !irq);

    p_swrst_r6: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!irq && trap_pc == '0 && !captured));

    p_pc_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (captured && clk_en && !soft_rst && clr == '0) |=> $stable(trap_pc));

    p_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (!clk_en && !soft_rst) |=> ($stable(irq) && $stable(trap_pc)));

    p_invalid_r10: assert property (@(posedge clk) disable iff (rst)
        !core_valid |-> raw == '0);
endmodule

bind sp_bounds_mon sbm_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst),
    .clk_en     (clk_en),
    .core_valid (core_valid),
    .irq        (irq),
    .trap_pc    (trap_pc_q),
    .captured   (cap_q),
    .raw        (raw_w),
    .arm        (arm_q),
    .clr        (clr_w)
);

// File: tb/sp_bounds_mon_tb_top.sv
module sp_bounds_mon_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en = 1'b1;
    logic        soft_rst = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] core_sp = '0;
    logic [31:0] core_pc = '0;
    logic        core_valid = 1'b0;
    logic        irq;

    int unsigned n_checks = 0;
    int unsigned n_fail = 0;
    bit          done = 1'b0;

    // bench model of the programmer-visible state
    logic [31:0] m_floor = '0, m_ceil = '0, m_pc = '0;
    logic [1:0]  m_watch = '0, m_arm = '0, m_st = '0;
    bit          m_cap = 1'b0;

    always #10 clk = ~clk;

    sp_bounds_mon dut_i (
        .clk(clk), .rst(rst), .clk_en(clk_en), .soft_rst(soft_rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .core_sp(core_sp), .core_pc(core_pc),
        .core_valid(core_valid), .irq(irq)
    );

    function automatic logic [1:0] exp_raw(logic [31:0] sp, bit v);
        logic [1:0] c;
        c[0] = v && (sp < m_floor);
        c[1] = v && (sp > m_ceil);
        return c & m_watch;
    endfunction

    function automatic logic [31:0] exp_read(logic [2:0] a, logic [31:0] sp, bit v);
        case (a)
            3'd0: return m_floor;
            3'd1: return m_ceil;
            3'd2: return {30'd0, m_watch};
            3'd3: return {30'd0, m_arm};
            3'd5: return {30'd0, exp_raw(sp, v)};
            3'd6: return m_pc;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(bit we, logic [2:0] a, logic [31:0] wd, logic [31:0] sp,
                        logic [31:0] pc, bit v, bit ce, bit sr, string tag);
        logic [1:0] r;
        logic [1:0] cl;
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = wd;
        core_sp = sp; core_pc = pc; core_valid = v;
        clk_en = ce; soft_rst = sr;
        #2;
        check({tag, " read"}, reg_rdata, exp_read(a, sp, v));
        r  = exp_raw(sp, v);
        cl = (we && ce && a == 3'd4) ? wd[1:0] : 2'b00;
        @(posedge clk);
        if (rst || sr) begin
            m_floor = '0; m_ceil = '0; m_watch = '0; m_arm = '0;
            m_st = '0; m_pc = '0; m_cap = 1'b0;
        end else if (ce) begin
            for (int i = 0; i < 2; i++) m_st[i] = cl[i] ? 1'b0 : (r[i] & m_arm[i]);
            if (cl != 2'b00) begin
                m_pc = '0; m_cap = 1'b0;
            end else if ((r != 2'b00) && !m_cap) begin
                m_pc = pc; m_cap = 1'b1;
            end
            if (we) begin
                case (a)
                    3'd0: m_floor = wd;
                    3'd1: m_ceil  = wd;
                    3'd2: m_watch = wd[1:0];
                    3'd3: m_arm   = wd[1:0];
                    default: ;
                endcase
            end
        end
        #2;
        check({tag, " irq"}, {31'd0, irq}, {31'd0, |m_st});
    endtask

    task automatic rd(logic [2:0] a, logic [31:0] sp, bit v, string tag);
        step(1'b0, a, 32'd0, sp, 32'h0, v, 1'b1, 1'b0, tag);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] wd, string tag);
        step(1'b1, a, wd, 32'h1800, 32'h0, 1'b0, 1'b1, 1'b0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        #1;
        // R6: reset state of every word
        for (int a = 0; a < 8; a++) rd(3'(a), 32'h0, 1'b0, "R6 reset");

        // R7: register access
        wr(3'd0, 32'h0000_1000, "R7 floor");
        wr(3'd1, 32'h0000_2000, "R7 ceil");
        wr(3'd2, 32'h3, "R7 watch");
        wr(3'd3, 32'h0, "R7 arm");
        rd(3'd0, 32'h1800, 1'b0, "R7 floor rb");
        rd(3'd1, 32'h1800, 1'b0, "R7 ceil rb");
        rd(3'd2, 32'h1800, 1'b0, "R7 watch rb");
        wr(3'd4, 32'h3, "R7 ack");
        rd(3'd4, 32'h1800, 1'b0, "R7 ack reads zero");
        rd(3'd7, 32'h1800, 1'b0, "R7 unmapped");

        // R10: invalid samples never flag
        rd(3'd5, 32'h3000, 1'b0, "R10 invalid high");
        rd(3'd5, 32'h0, 1'b0, "R10 invalid low");

        // R1 and R2: strict comparisons, polled without interrupt (arm is zero)
        rd(3'd5, 32'h2000, 1'b1, "R1 equal ceil");
        rd(3'd5, 32'h1000, 1'b1, "R2 equal floor");
        rd(3'd5, 32'h1FFF, 1'b1, "R1 inside");
        step(1'b0, 3'd5, 32'd0, 32'h2001, 32'hAAA0, 1'b1, 1'b1, 1'b0, "R1 above ceil");
        // R8: capture of first violation, then hold
        step(1'b0, 3'd6, 32'd0, 32'h2001, 32'hBBB0, 1'b1, 1'b1, 1'b0, "R8 captured pc");
        rd(3'd5, 32'h0FFF, 1'b1, "R2 below floor");
        rd(3'd6, 32'h0FFF, 1'b1, "R8 pc held");

        // R3: watch off masks the flag and the interrupt
        wr(3'd3, 32'h3, "R3 arm on");
        wr(3'd2, 32'h0, "R3 watch off");
        rd(3'd5, 32'h3000, 1'b1, "R3 flag masked");
        rd(3'd5, 32'h3000, 1'b1, "R3 irq stays low");

        // R4: armed violation raises irq one edge later
        wr(3'd2, 32'h3, "R4 watch on");
        rd(3'd5, 32'h3000, 1'b1, "R4 irq rises");
        rd(3'd5, 32'h3000, 1'b1, "R4 irq held");

        // R5: ack upper bit during a live violation; flag stays, pc re-arms
        step(1'b1, 3'd4, 32'h2, 32'h3000, 32'hCCC0, 1'b1, 1'b1, 1'b0, "R5 ack upper");
        rd(3'd5, 32'h3000, 1'b1, "R5 flag untouched");
        rd(3'd6, 32'h3000, 1'b1, "R8 recapture after ack");
        // ack of the other bit leaves the upper state alone
        step(1'b1, 3'd4, 32'h1, 32'h3000, 32'hDDD0, 1'b1, 1'b1, 1'b0, "R5 ack lower only");

        // R9: clock enable low freezes everything
        step(1'b1, 3'd0, 32'h5555, 32'h1800, 32'hEEE0, 1'b1, 1'b0, 1'b0, "R9 gated write");
        step(1'b1, 3'd4, 32'h3, 32'h1800, 32'hEEE0, 1'b1, 1'b0, 1'b0, "R9 gated ack");
        rd(3'd0, 32'h1800, 1'b1, "R9 floor unchanged");

        // R6: soft reset beats a simultaneous ack and load
        step(1'b1, 3'd4, 32'h3, 32'h3000, 32'h1, 1'b1, 1'b1, 1'b1, "R6 soft reset");
        for (int a = 0; a < 8; a++) rd(3'(a), 32'h3000, 1'b1, "R6 after soft reset");

        // seeded random phase near both bounds
        void'($urandom(32'd20240611));
        wr(3'd0, 32'h1000, "R7 floor");
        wr(3'd1, 32'h2000, "R7 ceil");
        for (int k = 0; k < 600; k++) begin
            logic [31:0] sp, wd;
            logic [2:0]  a;
            bit          we;
            case ($urandom % 4)
                0: sp = m_floor + ($urandom % 5) - 2;
                1: sp = m_ceil + ($urandom % 5) - 2;
                2: sp = $urandom;
                default: sp = 32'h1800;
            endcase
            a  = 3'($urandom % 8);
            we = ($urandom % 4) == 0;
            wd = (a <= 3'd1) ? 32'h1000 + ($urandom % 4096) : $urandom;
            step(we, a, wd, sp, $urandom, ($urandom % 4) != 0, ($urandom % 8) != 0,
                 ($urandom % 64) == 0, "R1/R2/R4/R5/R8/R9 random");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule